// File: doc/BRIEF.md
# SDRAM Low-Power Mode Controller

This block decides when an SDRAM device is put into a low-power state and when it is brought back. It watches the access-request line and the periodic auto-refresh tick. It then issues single-cycle command requests to the SDRAM command sequencer: enter or leave self-refresh, enter or leave power-down, enter deep power-down, issue an auto-refresh, or run a full re-initialization. The controller does not drive the clock-enable pin or meet its timing itself; the sequencer does that for each command.

Software picks one of three modes. In self-refresh the device keeps its own contents, so the controller holds back its auto-refreshes. In power-down the controller stays the owner of refresh: for every refresh tick it wakes the device, refreshes it and sends it back down. Deep power-down gives up the memory contents, and the controller only uses it when the mobile-device enable is set. An access that arrives while the device is in a low-power state first triggers the matching exit. The requester is stalled through a wait output until the wake-up latency has passed.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: With `lp_mode_i` = 1 (self-refresh) or 2 (power-down) and the timeout T in `idle_tmo_i`, the matching enter command pulses for one cycle exactly T+1 clock edges after the last edge that sampled `acc_req_i` high. No entry command appears earlier.
- R2: A timeout of zero gives entry on the first edge that samples `acc_req_i` low.
- R3: Any cycle with `acc_req_i` high restarts the idle count. A second access during the timeout postpones entry to T+1 edges after that access.
- R4: While in self-refresh, `ref_req_i` pulses produce no `ref_cmd_o`.
- R5: In power-down, a `ref_req_i` pulse yields `pd_exit_o`, then `ref_cmd_o`, then `pd_enter_o`, on three consecutive cycles, starting one edge after the pulse.
- R6: With `lp_mode_i` = 3 (deep power-down), entry requires `mobile_en_i` = 1. When it is allowed, `dpd_enter_o` pulses on the first edge with `acc_req_i` low, whatever the timeout. When `mobile_en_i` = 0 the block stays active.
- R7: An access in self-refresh or power-down makes `acc_wait_o` high at once. The matching exit command pulses one edge later, and `acc_wait_o` falls EXIT_CYC+1 edges after the request (EXIT_CYC default 4).
- R8: An access in deep power-down makes `init_req_o` pulse one edge later. `acc_wait_o` then falls INIT_CYC+1 edges after the request (INIT_CYC default 8).
- R9: With `lp_mode_i` = 0 no entry command is ever issued. While the device is active, a `ref_req_i` pulse appears on `ref_cmd_o` one edge later.
- R10: After reset every output is low, and at most one command output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lp_mode_i | input | 2 | 0 none, 1 self-refresh, 2 power-down, 3 deep power-down |
| mobile_en_i | input | 1 | Permits deep power-down |
| idle_tmo_i | input | TMO_W | Idle cycles before self-refresh or power-down entry |
| acc_req_i | input | 1 | Access request / device selected |
| ref_req_i | input | 1 | Periodic auto-refresh tick |
| acc_wait_o | output | 1 | Stalls the requester until the device is active |
| sr_enter_o | output | 1 | Enter self-refresh command |
| sr_exit_o | output | 1 | Exit self-refresh command |
| pd_enter_o | output | 1 | Enter power-down command |
| pd_exit_o | output | 1 | Exit power-down command |
| dpd_enter_o | output | 1 | Enter deep power-down command |
| init_req_o | output | 1 | Full re-initialization required |
| ref_cmd_o | output | 1 | Auto-refresh command |

## Verification
Every command output comes from a register, so it appears one edge after the state machine samples its cause. Entry lands T+1 edges after the last access edge, and the power-down refresh sequence fills the three edges after the tick. Only `acc_wait_o` is combinational, and it rises in the same cycle as the request. It falls EXIT_CYC+1 or INIT_CYC+1 edges later. The bench drives inputs on the falling edge, counts rising edges from the stimulus, and at each falling edge compares the outputs with the value due at that edge count. It also checks the cycle just before each due edge, so an early pulse is caught as well as a late one.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [1:0] {
    LP_NONE  = 2'd0,
    LP_SELF  = 2'd1,
    LP_PDOWN = 2'd2,
    LP_DEEP  = 2'd3
  } lp_mode_e;

  typedef enum logic [2:0] {
    ST_ACT,
    ST_SR,
    ST_PD,
    ST_PD_WAKE,
    ST_PD_REF,
    ST_DPD,
    ST_EXIT
  } lp_state_e;

  typedef struct packed {
    logic sr_enter;
    logic sr_exit;
    logic pd_enter;
    logic pd_exit;
    logic dpd_enter;
    logic init_req;
    logic ref_cmd;
  } lp_cmd_t;

endpackage

// File: rtl/sdram_lp_idle_cnt.sv
module sdram_lp_idle_cnt #(
  parameter int TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_req_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             hit_o
);

  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (acc_req_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = !acc_req_i && (cnt_q >= tmo_i);

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_req_i |=> (cnt_q == '0)); // R3
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) && !acc_req_i |=> (cnt_q == CNT_MAX)); // R3

endmodule

// File: rtl/sdram_lp_wake_tmr.sv
module sdram_lp_wake_tmr #(
  parameter int TMR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             last_o
);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == TMR_W'(1));

  AST_TMR_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && !load_i |=> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/sdram_lp_fsm.sv
module sdram_lp_fsm
  import sdram_lp_pkg::*;
#(
  parameter int EXIT_CYC = 4,
  parameter int INIT_CYC = 8,
  parameter int TMR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lp_mode_e         mode_i,
  input  logic             mobile_en_i,
  input  logic             acc_req_i,
  input  logic             ref_req_i,
  input  logic             tmo_hit_i,
  input  logic             tmr_last_i,
  output logic             tmr_load_o,
  output logic [TMR_W-1:0] tmr_val_o,
  output lp_cmd_t          cmd_o,
  output logic             acc_wait_o
);

  localparam logic [TMR_W-1:0] EXIT_V = TMR_W'(EXIT_CYC);
  localparam logic [TMR_W-1:0] INIT_V = TMR_W'(INIT_CYC);

  lp_state_e state_q, state_d;
  lp_cmd_t   cmd_q, cmd_d;
  logic      pend_q, pend_d;
  logic      ref_any;

  assign ref_any = ref_req_i | pend_q;

  always_comb begin
    state_d    = state_q;
    cmd_d      = '0;
    pend_d     = ref_any;
    tmr_load_o = 1'b0;
    tmr_val_o  = EXIT_V;
    unique case (state_q)
      ST_ACT: begin
        if (mode_i == LP_SELF && tmo_hit_i) begin
          state_d        = ST_SR;
          cmd_d.sr_enter = 1'b1;
          pend_d         = 1'b0;
        end else if (mode_i == LP_PDOWN && tmo_hit_i) begin
          state_d        = ST_PD;
          cmd_d.pd_enter = 1'b1;
        end else if (mode_i == LP_DEEP && mobile_en_i && !acc_req_i) begin
          state_d         = ST_DPD;
          cmd_d.dpd_enter = 1'b1;
          pend_d          = 1'b0;
        end else begin
          cmd_d.ref_cmd = ref_any;
          pend_d        = 1'b0;
        end
      end
      ST_SR: begin
        pend_d = 1'b0;  // device refreshes itself
        if (acc_req_i) begin
          state_d       = ST_EXIT;
          cmd_d.sr_exit = 1'b1;
          tmr_load_o    = 1'b1;
        end
      end
      ST_PD: begin
        if (ref_any) begin
          state_d       = ST_PD_WAKE;
          cmd_d.pd_exit = 1'b1;
          pend_d        = 1'b0;
        end else if (acc_req_i) begin
          state_d       = ST_EXIT;
          cmd_d.pd_exit = 1'b1;
          tmr_load_o    = 1'b1;
        end
      end
      ST_PD_WAKE: begin
        state_d       = ST_PD_REF;
        cmd_d.ref_cmd = 1'b1;
      end
      ST_PD_REF: begin
        if (acc_req_i) begin
          state_d = ST_ACT;  // already awake
        end else begin
          state_d        = ST_PD;
          cmd_d.pd_enter = 1'b1;
        end
      end
      ST_DPD: begin
        pend_d = 1'b0;  // contents are gone
        if (acc_req_i) begin
          state_d        = ST_EXIT;
          cmd_d.init_req = 1'b1;
          tmr_load_o     = 1'b1;
          tmr_val_o      = INIT_V;
        end
      end
      ST_EXIT: begin
        if (tmr_last_i) state_d = ST_ACT;
      end
      default: state_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACT;
      cmd_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      pend_q  <= pend_d;
    end
  end

  assign cmd_o      = cmd_q;
  assign acc_wait_o = acc_req_i && (state_q != ST_ACT);

  logic [6:0] cmd_vec;
  assign cmd_vec = cmd_q;

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_vec)); // R10
  AST_NO_REF_IN_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SR) |-> !cmd_q.ref_cmd); // R4
  AST_PD_WAKE_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.pd_exit && (state_q == ST_PD_WAKE) |=> cmd_q.ref_cmd); // R5
  AST_DPD_NEEDS_MOBILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.dpd_enter |-> $past(mobile_en_i)); // R6
  AST_SR_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.sr_enter |-> !$past(acc_req_i)); // R1
  AST_INIT_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.init_req && acc_req_i |-> acc_wait_o); // R8

endmodule

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
  import sdram_lp_pkg::*;
#(
  parameter int TMO_W    = 8,
  parameter int EXIT_CYC = 4,
  parameter int INIT_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       lp_mode_i,
  input  logic             mobile_en_i,
  input  logic [TMO_W-1:0] idle_tmo_i,
  input  logic             acc_req_i,
  input  logic             ref_req_i,
  output logic             acc_wait_o,
  output logic             sr_enter_o,
  output logic             sr_exit_o,
  output logic             pd_enter_o,
  output logic             pd_exit_o,
  output logic             dpd_enter_o,
  output logic             init_req_o,
  output logic             ref_cmd_o
);

  localparam int MAX_CYC = (EXIT_CYC > INIT_CYC) ? EXIT_CYC : INIT_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic             tmo_hit;
  logic             tmr_last;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  lp_cmd_t          cmd;

  sdram_lp_idle_cnt #(.TMO_W(TMO_W)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_req_i (acc_req_i),
    .tmo_i     (idle_tmo_i),
    .hit_o     (tmo_hit)
  );

  sdram_lp_wake_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .last_o (tmr_last)
  );

  sdram_lp_fsm #(
    .EXIT_CYC (EXIT_CYC),
    .INIT_CYC (INIT_CYC),
    .TMR_W    (TMR_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (lp_mode_e'(lp_mode_i)),
    .mobile_en_i (mobile_en_i),
    .acc_req_i   (acc_req_i),
    .ref_req_i   (ref_req_i),
    .tmo_hit_i   (tmo_hit),
    .tmr_last_i  (tmr_last),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cmd_o       (cmd),
    .acc_wait_o  (acc_wait_o)
  );

  assign sr_enter_o  = cmd.sr_enter;
  assign sr_exit_o   = cmd.sr_exit;
  assign pd_enter_o  = cmd.pd_enter;
  assign pd_exit_o   = cmd.pd_exit;
  assign dpd_enter_o = cmd.dpd_enter;
  assign init_req_o  = cmd.init_req;
  assign ref_cmd_o   = cmd.ref_cmd;

endmodule

// File: tb/sdram_lp_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdram_lp_ctrl_tb_top;

  localparam int TMO_W    = 8;
  localparam int EXIT_CYC = 4;
  localparam int INIT_CYC = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       lp_mode_i = 2'd0;
  logic             mobile_en_i = 1'b0;
  logic [TMO_W-1:0] idle_tmo_i = '0;
  logic             acc_req_i = 1'b0;
  logic             ref_req_i = 1'b0;
  logic acc_wait_o, sr_enter_o, sr_exit_o, pd_enter_o, pd_exit_o;
  logic dpd_enter_o, init_req_o, ref_cmd_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  sdram_lp_ctrl #(.TMO_W(TMO_W), .EXIT_CYC(EXIT_CYC), .INIT_CYC(INIT_CYC)) dut_i (
    .clk_i, .rst_ni, .lp_mode_i, .mobile_en_i, .idle_tmo_i, .acc_req_i, .ref_req_i,
    .acc_wait_o, .sr_enter_o, .sr_exit_o, .pd_enter_o, .pd_exit_o,
    .dpd_enter_o, .init_req_o, .ref_cmd_o
  );

  function automatic int cmd_bits();
    return int'({sr_enter_o, sr_exit_o, pd_enter_o, pd_exit_o,
                 dpd_enter_o, init_req_o, ref_cmd_o});
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // Hold an access until active, then release; returns with the release driven.
  task automatic start_idle(int mode, int tmo, bit mob);
    @(negedge clk_i);
    acc_req_i   = 1'b1;
    lp_mode_i   = 2'(mode);
    idle_tmo_i  = TMO_W'(tmo);
    mobile_en_i = mob;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (!acc_wait_o) break;
      step();
    end
    step();
    acc_req_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset cmds", cmd_bits(), 0);
    check("R10 reset wait", int'(acc_wait_o), 0);
  endtask

  task automatic t_sr_entry();
    start_idle(1, 3, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      step();
      check($sformatf("R1 sr_enter k=%0d", k), int'(sr_enter_o), (k == 4) ? 1 : 0);
    end
  endtask

  task automatic t_sr_no_ref();
    ref_req_i = 1'b1;
    step();
    ref_req_i = 1'b0;
    check("R4 no ref in self-refresh", int'(ref_cmd_o), 0);
    for (int k = 0; k < 2; k++) begin
      step();
      check("R4 no ref later", int'(ref_cmd_o), 0);
    end
  endtask

  task automatic t_exit(bit is_sr);
    acc_req_i = 1'b1;
    #1;
    check("R7 wait at request", int'(acc_wait_o), 1);
    for (int k = 1; k <= EXIT_CYC + 1; k++) begin
      step();
      if (k == 1)
        check("R7 exit cmd", int'(is_sr ? sr_exit_o : pd_exit_o), 1);
      check($sformatf("R7 wait k=%0d", k), int'(acc_wait_o), (k <= EXIT_CYC) ? 1 : 0);
    end
  endtask

  task automatic t_pd_zero();
    start_idle(2, 0, 1'b0);
    step();
    check("R2 pd_enter zero timeout", int'(pd_enter_o), 1);
  endtask

  task automatic t_pd_refresh();
    step();
    ref_req_i = 1'b1;
    step();
    ref_req_i = 1'b0;
    check("R5 pd_exit", int'(pd_exit_o), 1);
    step();
    check("R5 ref_cmd", int'(ref_cmd_o), 1);
    step();
    check("R5 pd_enter", int'(pd_enter_o), 1);
    step();
    check("R5 quiet", cmd_bits(), 0);
  endtask

  task automatic t_dpd_blocked();
    start_idle(3, 0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      step();
      check("R6 no dpd without mobile", int'(dpd_enter_o), 0);
    end
    ref_req_i = 1'b1;
    step();
    ref_req_i = 1'b0;
    check("R9 ref forwarded while active", int'(ref_cmd_o), 1);
  endtask

  task automatic t_dpd();
    start_idle(3, 50, 1'b1);
    step();
    check("R6 dpd_enter ignores timeout", int'(dpd_enter_o), 1);
    step();
    acc_req_i = 1'b1;
    #1;
    check("R8 wait at request", int'(acc_wait_o), 1);
    for (int k = 1; k <= INIT_CYC + 1; k++) begin
      step();
      if (k == 1) check("R8 init_req", int'(init_req_o), 1);
      check($sformatf("R8 wait k=%0d", k), int'(acc_wait_o), (k <= INIT_CYC) ? 1 : 0);
    end
  endtask

  task automatic t_none();
    start_idle(0, 0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      step();
      check("R9 no entry in mode none", cmd_bits(), 0);
    end
  endtask

  task automatic t_restart();
    start_idle(1, 5, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R3 no early entry", int'(sr_enter_o), 0);
    end
    acc_req_i = 1'b1;
    step();
    acc_req_i = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      step();
      check($sformatf("R3 entry after restart k=%0d", k), int'(sr_enter_o), (k == 6) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_sr_entry();
    t_sr_no_ref();
    t_exit(1'b1);
    t_pd_zero();
    t_pd_refresh();
    t_exit(1'b0);
    t_dpd_blocked();
    t_dpd();
    t_none();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule